// File: doc/BRIEF.md
# Block Repeat-Step Engine

This block carries out a single iteration of the byte-string operations found in an 8-bit processor core. Three operations are supported. A move copies a byte from the source pointer to the destination pointer. A scan compares the accumulator against the byte at the source pointer. A port emit sends the byte at the source pointer to an output port. Each step updates the pointers, the count register and the flag byte. It also reports whether the surrounding sequencer should run the same instruction again.

The caller presents the register values and an operation code, then pulses `start`. The engine reads memory through a synchronous byte port whose read data arrives one cycle after the address. It performs the write or the port strobe, registers the results, and raises `done` for exactly one cycle. When `repeat_req` is high at that point, the caller rewinds its program counter to the instruction address and issues the step again. Instruction fetch and program-counter handling stay with the caller.

Top module: `blk_step_engine`

## Requirements
- R1: While reset is held (synchronous, active low) and after it is released, `done`, `mem_we`, `port_we` and `repeat_req` are low, and `hl_out`, `de_out`, `bc_out` and `flags_out` are zero.
- R2: `op[1:0]` selects the kind (0 move, 1 scan, 2 port emit, 3 reserved), `op[2]` selects decrement (1) or increment (0), and `op[3]` enables repetition. A `start` seen while idle presents `hl_in` on `mem_addr` in the next cycle. `done` is high for exactly one cycle, in the fourth cycle after the start edge. `start` is ignored while a step is in progress. The reserved kind completes with no write, no strobe and all register outputs equal to their inputs.
- R3: A move writes the byte read at HL to address DE with a single `mem_we` cycle. HL and DE both step by one in the selected direction, and BC drops by one (16-bit wrap).
- R4: The flag byte is laid out S=bit7, Z=6, Y=5, H=4, X=3, P=2, N=1, C=0. After a move, H=0, N=0, and P=1 exactly when the new BC is non-zero. X takes bit 3 and Y takes bit 1 of the 8-bit sum of the moved byte and A. S, Z and C keep their input values.
- R5: A scan performs no memory write. HL steps in the selected direction, BC drops by one, and DE is unchanged. S and Z come from A minus the byte. H is the borrow out of bit 3. P=1 when the new BC is non-zero, N=1, and C keeps its input value.
- R6: After a scan, X takes bit 3 and Y takes bit 1 of (A minus byte minus the new H).
- R7: A port emit pulses `port_we` once, with `port_addr` equal to the low half of BC and `port_data` equal to the byte read at HL. The high half of BC drops by one, the low half and DE are unchanged, and HL always increments, whatever `op[2]` says.
- R8: After a port emit, Z=1 exactly when the new high half of BC is zero, N=1, X takes bit 3 and Y takes bit 5 of the emitted byte. S, H, P and C keep their input values.
- R9: `repeat_req` is high only when `op[3]` is set. For a move it also needs the new BC to be non-zero. For a scan it needs a non-zero difference and a non-zero new BC. For a port emit it needs a non-zero new high half of BC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one step (accepted when idle) |
| op | input | 4 | Operation code: kind, direction, repeat enable |
| acc_in | input | 8 | Accumulator value |
| flags_in | input | 8 | Flag byte before the step |
| hl_in | input | AW | Source pointer |
| de_in | input | AW | Destination pointer |
| bc_in | input | CW | Count register; high half is the port-emit counter, low half the port number |
| mem_addr | output | AW | Memory byte address |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Memory write enable |
| port_addr | output | CW/2 | Output port number |
| port_data | output | 8 | Output port data |
| port_we | output | 1 | Output port write strobe |
| done | output | 1 | One-cycle completion pulse |
| hl_out | output | AW | Updated source pointer |
| de_out | output | AW | Updated destination pointer |
| bc_out | output | CW | Updated count register |
| flags_out | output | 8 | Updated flag byte |
| repeat_req | output | 1 | Caller must re-run the instruction |

## Verification
The bench builds the engine with its default values: 16-bit pointers (AW) and a 16-bit count register (CW). These widths bring several carry and borrow cases within reach. A count of 0x0100 borrows across the two halves of the count register. A source pointer of 0x00FF carries into the upper pointer byte. A port-emit counter going from one to zero is distinguished from a non-zero port number in the low half. The scan vectors cover a half borrow that changes the X/Y source value, an exact match with the count still non-zero, and a count running out without a match.

// File: rtl/blk_pkg.sv
// Package: shared types and flag bit positions for the block-step engine.
// Assumes an 8-bit data path and flag byte.
package blk_pkg;
    localparam int BYTE_W = 8;

    // Flag bit positions inside the flag byte
    localparam int FL_C = 0;
    localparam int FL_N = 1;
    localparam int FL_P = 2;
    localparam int FL_X = 3;
    localparam int FL_H = 4;
    localparam int FL_Y = 5;
    localparam int FL_Z = 6;
    localparam int FL_S = 7;

    typedef enum logic [1:0] {
        KIND_MOVE = 2'd0,
        KIND_SCAN = 2'd1,
        KIND_EMIT = 2'd2,
        KIND_RSV  = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_READ = 3'd1,
        PH_EXEC = 3'd2,
        PH_UPD  = 3'd3,
        PH_DONE = 3'd4
    } phase_e;

    typedef struct packed {
        logic  rpt;
        logic  dn;
        kind_e kind;
    } op_t;
endpackage

// File: rtl/blk_seq.sv
// Module: blk_seq
// Fixed five-phase sequencer: idle, read, execute, update, done.
// Assumes memory read data is valid in the cycle after the read phase.
// start is only looked at in the idle phase.
module blk_seq
    import blk_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output phase_e phase,
    output logic   done
);
    phase_e phase_q;

    // Advance one phase per cycle; leave idle only on start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE: phase_q <= start ? PH_READ : PH_IDLE;
                PH_READ: phase_q <= PH_EXEC;
                PH_EXEC: phase_q <= PH_UPD;
                PH_UPD:  phase_q <= PH_DONE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Expose the phase and the completion pulse
    always_comb begin
        phase = phase_q;
        done  = (phase_q == PH_DONE);
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    read_follows_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_READ) |-> $past(phase_q) == PH_IDLE);
endmodule

// File: rtl/blk_ptr_step.sv
// Module: blk_ptr_step
// Steps a pointer by one in either direction, or passes it through.
// Wraps modulo 2**W.
module blk_ptr_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    input  logic         en,
    input  logic         dn,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONE = W'(1);

    // Select hold, decrement or increment
    always_comb begin
        if (!en)     nxt = val;
        else if (dn) nxt = val - ONE;
        else         nxt = val + ONE;
    end
endmodule

// File: rtl/blk_calc.sv
// Module: blk_calc
// Combinational result logic for one step. It computes the new pointers,
// the count register, the flag byte and the repeat request from the
// latched inputs and the byte read from memory.
// Assumes CW is even: its high half is the port-emit counter.
module blk_calc
    import blk_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  op_t                op,
    input  logic [BYTE_W-1:0]  acc,
    input  logic [BYTE_W-1:0]  flg,
    input  logic [AW-1:0]      hl,
    input  logic [AW-1:0]      de,
    input  logic [CW-1:0]      cnt,
    input  logic [BYTE_W-1:0]  data,
    output logic [AW-1:0]      hl_n,
    output logic [AW-1:0]      de_n,
    output logic [CW-1:0]      cnt_n,
    output logic [BYTE_W-1:0]  flg_n,
    output logic               rpt_n
);
    localparam int HALF = CW / 2;

    logic [BYTE_W-1:0] mv_sum;
    logic [BYTE_W-1:0] sc_diff;
    logic              sc_half;
    logic [BYTE_W-1:0] sc_adj;
    logic [CW-1:0]     cnt_dec;
    logic [HALF-1:0]   hi_dec;
    logic              hl_en, hl_dn, de_en;

    // Intermediate arithmetic shared by the kinds
    always_comb begin
        mv_sum  = data + acc;
        sc_diff = acc - data;
        sc_half = (acc[3:0] < data[3:0]);
        sc_adj  = sc_diff - BYTE_W'(sc_half);
        cnt_dec = cnt - CW'(1);
        hi_dec  = cnt[CW-1:HALF] - HALF'(1);
    end

    // Pointer step controls per kind
    always_comb begin
        hl_en = (op.kind != KIND_RSV);
        hl_dn = (op.kind == KIND_EMIT) ? 1'b0 : op.dn;
        de_en = (op.kind == KIND_MOVE);
    end

    blk_ptr_step #(.W(AW)) i_hl_step (.val(hl), .en(hl_en), .dn(hl_dn), .nxt(hl_n));
    blk_ptr_step #(.W(AW)) i_de_step (.val(de), .en(de_en), .dn(op.dn), .nxt(de_n));

    // Count, flag and repeat results per kind
    always_comb begin
        cnt_n = cnt;
        flg_n = flg;
        rpt_n = 1'b0;
        unique case (op.kind)
            KIND_MOVE: begin
                cnt_n       = cnt_dec;
                flg_n[FL_H] = 1'b0;
                flg_n[FL_N] = 1'b0;
                flg_n[FL_P] = (cnt_dec != '0);
                flg_n[FL_X] = mv_sum[3];
                flg_n[FL_Y] = mv_sum[1];
                rpt_n       = op.rpt && (cnt_dec != '0);
            end
            KIND_SCAN: begin
                cnt_n       = cnt_dec;
                flg_n[FL_S] = sc_diff[BYTE_W-1];
                flg_n[FL_Z] = (sc_diff == '0);
                flg_n[FL_H] = sc_half;
                flg_n[FL_P] = (cnt_dec != '0);
                flg_n[FL_N] = 1'b1;
                flg_n[FL_X] = sc_adj[3];
                flg_n[FL_Y] = sc_adj[1];
                rpt_n       = op.rpt && (sc_diff != '0) && (cnt_dec != '0);
            end
            KIND_EMIT: begin
                cnt_n       = {hi_dec, cnt[HALF-1:0]};
                flg_n[FL_Z] = (hi_dec == '0);
                flg_n[FL_N] = 1'b1;
                flg_n[FL_X] = data[3];
                flg_n[FL_Y] = data[5];
                rpt_n       = op.rpt && (hi_dec != '0);
            end
            default: begin
                cnt_n = cnt;
            end
        endcase
    end
endmodule

// File: rtl/blk_step_engine.sv
// Module: blk_step_engine (top)
// Runs one iteration of a move, scan or port-emit string operation.
// It latches the register inputs on start, reads the byte at HL, writes it
// to DE (move) or strobes the port (emit), then registers the results and
// pulses done. Assumes a synchronous memory with one cycle of read latency.
module blk_step_engine
    import blk_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        op,
    input  logic [7:0]        acc_in,
    input  logic [7:0]        flags_in,
    input  logic [AW-1:0]     hl_in,
    input  logic [AW-1:0]     de_in,
    input  logic [CW-1:0]     bc_in,
    output logic [AW-1:0]     mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic [CW/2-1:0]   port_addr,
    output logic [7:0]        port_data,
    output logic              port_we,
    output logic              done,
    output logic [AW-1:0]     hl_out,
    output logic [AW-1:0]     de_out,
    output logic [CW-1:0]     bc_out,
    output logic [7:0]        flags_out,
    output logic              repeat_req
);
    localparam int HALF = CW / 2;

    phase_e            phase;
    op_t               op_q;
    logic [BYTE_W-1:0] acc_q, flg_q, byte_q;
    logic [AW-1:0]     hl_q, de_q;
    logic [CW-1:0]     bc_q;
    logic [AW-1:0]     hl_n, de_n;
    logic [CW-1:0]     bc_n;
    logic [BYTE_W-1:0] flg_n;
    logic              rpt_n;

    blk_seq i_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .phase (phase),
        .done  (done)
    );

    // Latch the operands when a step is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= '0;
            acc_q <= '0;
            flg_q <= '0;
            hl_q  <= '0;
            de_q  <= '0;
            bc_q  <= '0;
        end else if (phase == PH_IDLE && start) begin
            op_q  <= op_t'(op);
            acc_q <= acc_in;
            flg_q <= flags_in;
            hl_q  <= hl_in;
            de_q  <= de_in;
            bc_q  <= bc_in;
        end
    end

    // Capture the byte returned by memory in the execute phase
    always_ff @(posedge clk) begin
        if (!rst_n)               byte_q <= '0;
        else if (phase == PH_EXEC) byte_q <= mem_rdata;
    end

    // Drive the memory and port sides
    always_comb begin
        mem_we    = (phase == PH_EXEC) && (op_q.kind == KIND_MOVE);
        mem_addr  = mem_we ? de_q : hl_q;
        mem_wdata = mem_rdata;
        port_we   = (phase == PH_EXEC) && (op_q.kind == KIND_EMIT);
        port_addr = bc_q[HALF-1:0];
        port_data = mem_rdata;
    end

    blk_calc #(.AW(AW), .CW(CW)) i_calc (
        .op    (op_q),
        .acc   (acc_q),
        .flg   (flg_q),
        .hl    (hl_q),
        .de    (de_q),
        .cnt   (bc_q),
        .data  (byte_q),
        .hl_n  (hl_n),
        .de_n  (de_n),
        .cnt_n (bc_n),
        .flg_n (flg_n),
        .rpt_n (rpt_n)
    );

    // Register the results at the end of the update phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hl_out     <= '0;
            de_out     <= '0;
            bc_out     <= '0;
            flags_out  <= '0;
            repeat_req <= 1'b0;
        end else if (phase == PH_UPD) begin
            hl_out     <= hl_n;
            de_out     <= de_n;
            bc_out     <= bc_n;
            flags_out  <= flg_n;
            repeat_req <= rpt_n;
        end else if (phase == PH_IDLE && start) begin
            repeat_req <= 1'b0;
        end
    end

    // R3
    wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && port_we));

    // R5
    scan_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> op_q.kind == KIND_MOVE);

    // R9
    rpt_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && repeat_req) |-> op_q.rpt);

    // R8
    emit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q.kind == KIND_EMIT) |-> flags_out[FL_Z] == (bc_out[CW-1:HALF] == '0));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> (!mem_we && !port_we));
endmodule

// File: tb/test_blk_step_engine.sv
module test_blk_step_engine;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;

    typedef struct packed {
        logic [3:0]  op;
        logic [7:0]  acc;
        logic [7:0]  fl;
        logic [15:0] hl;
        logic [15:0] de;
        logic [15:0] bc;
        logic [7:0]  dat;
        logic [15:0] ehl;
        logic [15:0] ede;
        logic [15:0] ebc;
        logic [7:0]  efl;
        logic        erp;
    } vec_t;

    // op, acc, flags, hl, de, bc, byte | exp hl, de, bc, flags, repeat
    localparam vec_t VECS [NV] = '{
        '{4'b0000, 8'h10, 8'h00, 16'h0040, 16'h0080, 16'h0003, 8'h2A, 16'h0041, 16'h0081, 16'h0002, 8'h2C, 1'b0},
        '{4'b1100, 8'h00, 8'hC1, 16'h0050, 16'h0090, 16'h0001, 8'h00, 16'h004F, 16'h008F, 16'h0000, 8'hC1, 1'b0},
        '{4'b1000, 8'h01, 8'h00, 16'h00FF, 16'h0010, 16'h0100, 8'h07, 16'h0100, 16'h0011, 16'h00FF, 8'h0C, 1'b1},
        '{4'b1001, 8'h50, 8'h01, 16'h0020, 16'h0099, 16'h0005, 8'h21, 16'h0021, 16'h0099, 16'h0004, 8'h3F, 1'b1},
        '{4'b1101, 8'h33, 8'h00, 16'h0030, 16'h0099, 16'h0009, 8'h33, 16'h002F, 16'h0099, 16'h0008, 8'h46, 1'b0},
        '{4'b1001, 8'h10, 8'h00, 16'h0060, 16'h0099, 16'h0001, 8'h80, 16'h0061, 16'h0099, 16'h0000, 8'h82, 1'b0},
        '{4'b1010, 8'h00, 8'h81, 16'h0070, 16'h0099, 16'h0312, 8'h28, 16'h0071, 16'h0099, 16'h0212, 8'hAB, 1'b1},
        '{4'b1110, 8'h00, 8'h00, 16'h00A0, 16'h0099, 16'h01FE, 8'h01, 16'h00A1, 16'h0099, 16'h00FE, 8'h42, 1'b0},
        '{4'b1011, 8'h00, 8'h55, 16'h00B0, 16'h00C0, 16'h0404, 8'h11, 16'h00B0, 16'h00C0, 16'h0404, 8'h55, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic [7:0]  acc_in = '0, flags_in = '0;
    logic [15:0] hl_in = '0, de_in = '0, bc_in = '0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0, mem_wdata;
    logic        mem_we;
    logic [7:0]  port_addr, port_data;
    logic        port_we, done, repeat_req;
    logic [15:0] hl_out, de_out, bc_out;
    logic [7:0]  flags_out;

    logic [7:0]  mem [256];
    int          n_chk = 0, n_fail = 0;
    int          wr_cnt = 0, pw_cnt = 0, done_cnt = 0;
    logic [7:0]  wr_addr = '0, wr_data = '0, pw_addr = '0, pw_data = '0;
    logic [15:0] first_addr = '0;
    int          cyc_since = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    blk_step_engine i_blk_step_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .acc_in(acc_in), .flags_in(flags_in), .hl_in(hl_in), .de_in(de_in), .bc_in(bc_in),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .port_addr(port_addr), .port_data(port_data), .port_we(port_we),
        .done(done), .hl_out(hl_out), .de_out(de_out), .bc_out(bc_out),
        .flags_out(flags_out), .repeat_req(repeat_req)
    );

    // Synchronous memory model with one cycle of read latency, plus write/strobe monitors
    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            wr_cnt  <= wr_cnt + 1;
            wr_addr <= mem_addr[7:0];
            wr_data <= mem_wdata;
        end
        if (port_we) begin
            pw_cnt  <= pw_cnt + 1;
            pw_addr <= port_addr;
            pw_data <= port_data;
        end
        if (done) done_cnt <= done_cnt + 1;
        if (cyc_since == 1) first_addr <= mem_addr;
        mem_rdata <= mem[mem_addr[7:0]];
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Launch one step and wait at falling edges until done; returns cycles to done
    task automatic run_step(input vec_t v, input int hold, output int cycles);
        @(negedge clk);
        mem[v.hl[7:0]] = v.dat;
        if (v.op[1:0] == 2'd0) mem[v.de[7:0]] = 8'hEE;
        wr_cnt = 0; pw_cnt = 0; done_cnt = 0;
        op = v.op; acc_in = v.acc; flags_in = v.fl;
        hl_in = v.hl; de_in = v.de; bc_in = v.bc;
        start = 1'b1;
        cyc_since = 1;
        @(negedge clk);
        if (hold == 0) start = 1'b0;
        cycles = 1;
        while (!done && cycles < 20) begin
            @(negedge clk);
            cycles++;
            if (cycles > hold) start = 1'b0;
        end
        start = 1'b0;
        cyc_since = 0;
    endtask

    initial begin
        int cyc;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!done && !mem_we && !port_we && !repeat_req, "R1", "strobes in reset",
            {done, mem_we, port_we, repeat_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hl_out == 0 && de_out == 0 && bc_out == 0 && flags_out == 0, "R1", "outputs after reset",
            {hl_out, de_out}, 0);
        chk(!done && !repeat_req, "R1", "done/repeat after reset", {done, repeat_req}, 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string tag;
            v = VECS[i];
            tag = (v.op[1:0] == 2'd0) ? "R3" : (v.op[1:0] == 2'd1) ? "R5" :
                  (v.op[1:0] == 2'd2) ? "R7" : "R2";
            run_step(v, 0, cyc);
            // R2: done in the fourth cycle, address HL presented first
            chk(cyc == 4, "R2", "cycles to done", cyc, 4);
            chk(first_addr == v.hl, "R2", "first address", first_addr, v.hl);
            chk(hl_out == v.ehl, tag, "hl_out", hl_out, v.ehl);
            chk(de_out == v.ede, tag, "de_out", de_out, v.ede);
            chk(bc_out == v.ebc, tag, "bc_out", bc_out, v.ebc);
            // R4 R6 R8: flag byte
            chk(flags_out == v.efl, (v.op[1:0] == 2'd0) ? "R4" : (v.op[1:0] == 2'd1) ? "R6" :
                (v.op[1:0] == 2'd2) ? "R8" : "R2", "flags_out", flags_out, v.efl);
            // R9: repeat decision
            chk(repeat_req == v.erp, "R9", "repeat_req", repeat_req, v.erp);
            @(negedge clk);
            chk(!done, "R2", "done one cycle", done, 0);
            if (v.op[1:0] == 2'd0) begin
                chk(wr_cnt == 1, "R3", "write count", wr_cnt, 1);
                chk(wr_addr == v.de[7:0] && mem[v.de[7:0]] == v.dat, "R3", "written byte",
                    mem[v.de[7:0]], v.dat);
            end else begin
                chk(wr_cnt == 0, (v.op[1:0] == 2'd1) ? "R5" : "R2", "no memory write", wr_cnt, 0);
            end
            if (v.op[1:0] == 2'd2) begin
                chk(pw_cnt == 1, "R7", "strobe count", pw_cnt, 1);
                chk(pw_addr == v.bc[7:0], "R7", "port number", pw_addr, v.bc[7:0]);
                chk(pw_data == v.dat, "R7", "port byte", pw_data, v.dat);
            end else begin
                chk(pw_cnt == 0, "R2", "no strobe", pw_cnt, 0);
            end
        end

        // R2: start held high while busy does not launch a second step
        run_step(VECS[0], 3, cyc);
        chk(cyc == 4, "R2", "cycles with start held", cyc, 4);
        repeat (6) @(negedge clk);
        chk(done_cnt == 1, "R2", "single completion while busy", done_cnt, 1);
        chk(wr_cnt == 1, "R2", "single write while busy", wr_cnt, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule